// File: doc/BRIEF.md
# Local Bus Hold/Acknowledge Arbitration Unit

This unit lets one node share a multi-master local address/data bus with other masters through a pair of active-low handshake lines, one asking for the bus (HOLD) and one granting it (HOLD-ACKNOWLEDGE). A 2-bit mode value picks the role. In requester mode the node asks another master for the bus. In arbiter mode the node owns the bus and lends it to others. The two remaining codes turn the handshake off. The role decides which of two shared pins carries HOLD and which carries HOLD-ACKNOWLEDGE, and in which direction each one points.

A DMA engine tells the unit when a transfer needs external memory and when its whole operation is over. The CPU supplies a strobe at each instruction boundary. The unit answers with a grant that allows the local DMA to use the bus, and with drive and enable controls for both pins. Every incoming handshake pin passes through a two-flop synchronizer before it is used.

Top module: `busshare_ctrl`

## Requirements
- R1: After reset the grant is low. In any mode, an enabled pin drives 1, which is the inactive level.
- R2: With mode 2'b00, both pin enables are low. The grant equals dma_req_i AND dma_ext_i in the same cycle, with no handshake.
- R3: With mode 2'b11, both pin enables are low and the grant stays low whatever the inputs are.
- R4: With mode 2'b01 (requester), pin A is an output (pin_a_oe=1) carrying HOLD, and pin B is an input (pin_b_oe=0) carrying HOLD-ACKNOWLEDGE.
- R5: In requester mode, pin_a_o goes low on the clock edge that first sees dma_req_i and dma_ext_i both high. A request with dma_ext_i low never drives pin A low.
- R6: In requester mode, the grant rises on the third clock edge after pin_b_i goes low (two synchronizer flops plus one state update). Before that edge the grant stays low.
- R7: In requester mode, once the grant is given, HOLD stays low and the grant stays high until dma_done_i is seen, even if dma_req_i drops. Both are released on the edge that samples dma_done_i.
- R8: With mode 2'b10 (arbiter), pin A is an input carrying HOLD (pin_a_oe=0) and pin B is an output carrying HOLD-ACKNOWLEDGE (pin_b_oe=1).
- R9: In arbiter mode, pin_b_o falls only on an edge where insn_bound_i is high and the synchronized pin A is low. No number of idle cycles without the strobe asserts it.
- R10: In arbiter mode, the grant is never high while pin_b_o is low. A local DMA that is in progress keeps the bus, and a pending external HOLD waits until it completes.
- R11: In arbiter mode, pin_b_o returns high on the third edge after pin_a_i goes high. A pending local request gets the grant on the following edge.
- R12: In arbiter mode with no external HOLD, the grant rises one edge after dma_req_i and dma_ext_i are both seen high. It falls on the edge that samples dma_done_i.
- R13: Changing the mode returns the unit to idle on the next edge, which drops any grant and releases any handshake line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Role select: 00 off, 01 requester, 10 arbiter, 11 invalid (off) |
| dma_req_i | input | 1 | DMA engine has a transfer pending |
| dma_ext_i | input | 1 | The pending transfer touches external memory |
| dma_done_i | input | 1 | Whole DMA operation complete (one-cycle strobe) |
| insn_bound_i | input | 1 | CPU instruction boundary strobe |
| pin_a_i | input | 1 | Pin A sampled level (HOLD input in arbiter mode) |
| pin_b_i | input | 1 | Pin B sampled level (HOLD-ACKNOWLEDGE input in requester mode) |
| pin_a_o | output | 1 | Pin A drive level, active low |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_o | output | 1 | Pin B drive level, active low |
| pin_b_oe | output | 1 | Pin B output enable |
| dma_grant_o | output | 1 | Local DMA may use the external bus |

## Verification
The bench builds the unit with its default of two synchronizer stages. With that setting the latency from each pin edge to the reaction can be counted exactly, and the bench checks every count against a figure of 3 or 4 edges computed from the stage count. It sweeps all four mode codes and every combination of request and external flag. It varies the delay before HOLD-ACKNOWLEDGE arrives, and the number of idle cycles before the instruction strobe, over several values. Mode changes in the middle of a transfer, and an external HOLD that arrives during a local DMA, are driven as separate cases.

// File: rtl/busshare_pkg.sv
// Package: shared types for the local bus arbitration unit.
// Assumes: mode codes are fixed by the mode register layout {arbiter, requester}.
package busshare_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF     = 2'b00,
        MODE_REQ     = 2'b01,
        MODE_ARB     = 2'b10,
        MODE_INVALID = 2'b11
    } bus_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQ_WAIT = 3'd1,
        ST_REQ_OWN  = 3'd2,
        ST_ARB_EXT  = 3'd3,
        ST_ARB_DMA  = 3'd4
    } bus_state_e;
endpackage

// File: rtl/busshare_sync.sv
// Module: multi-bit synchronizer with a configurable number of flop stages.
// Assumes: each bit is independent; the reset value is the inactive pin level.
module busshare_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift each bit one stage further per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= {WIDTH{RST_VAL}};
                else if (s == 0)
                    chain[s] <= d_i;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain[LAST];
endmodule

// File: rtl/busshare_fsm.sv
// Module: role state machine for requesting or lending the local bus.
// Assumes: hold/holda inputs are already synchronized and active-high here;
// dma_need_i already excludes CPU and internal-only transfers.
module busshare_fsm
    import busshare_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_mode_e mode_i,
    input  logic      dma_need_i,
    input  logic      dma_done_i,
    input  logic      insn_bound_i,
    input  logic      hold_in_i,
    input  logic      holda_in_i,
    output logic      hold_out_o,
    output logic      holda_out_o,
    output logic      bus_own_o
);
    bus_state_e state_q, state_d;
    bus_mode_e  mode_q;

    // Purpose: remember the previous mode so a change can abort activity.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_i;
    end

    // Purpose: compute the next role state.
    always_comb begin
        state_d = state_q;
        if (mode_i != mode_q) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (mode_i == MODE_REQ && dma_need_i)
                        state_d = ST_REQ_WAIT;
                    else if (mode_i == MODE_ARB) begin
                        if (hold_in_i && insn_bound_i) state_d = ST_ARB_EXT;
                        else if (dma_need_i)           state_d = ST_ARB_DMA;
                    end
                end
                ST_REQ_WAIT: if (holda_in_i)  state_d = ST_REQ_OWN;
                ST_REQ_OWN:  if (dma_done_i)  state_d = ST_IDLE;
                ST_ARB_EXT:  if (!hold_in_i)  state_d = ST_IDLE;
                ST_ARB_DMA:  if (dma_done_i)  state_d = ST_IDLE;
                default:                      state_d = ST_IDLE;
            endcase
        end
    end

    // Purpose: hold the role state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign hold_out_o  = (state_q == ST_REQ_WAIT) || (state_q == ST_REQ_OWN);
    assign holda_out_o = (state_q == ST_ARB_EXT);
    assign bus_own_o   = (state_q == ST_REQ_OWN) || (state_q == ST_ARB_DMA);
endmodule

// File: rtl/busshare_pins.sv
// Module: maps handshake activity onto the two shared pins by mode.
// Assumes: pins are active low; a disabled pin is tri-stated and idles high.
module busshare_pins
    import busshare_pkg::*;
(
    input  bus_mode_e mode_i,
    input  logic      hold_out_i,
    input  logic      holda_out_i,
    output logic      pin_a_o,
    output logic      pin_a_oe,
    output logic      pin_b_o,
    output logic      pin_b_oe
);
    // Purpose: choose direction and level of each pin for the current role.
    always_comb begin
        pin_a_o  = 1'b1;
        pin_b_o  = 1'b1;
        pin_a_oe = 1'b0;
        pin_b_oe = 1'b0;
        case (mode_i)
            MODE_REQ: begin
                pin_a_oe = 1'b1;
                pin_a_o  = ~hold_out_i;
            end
            MODE_ARB: begin
                pin_b_oe = 1'b1;
                pin_b_o  = ~holda_out_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/busshare_ctrl.sv
// Module: top of the local bus arbitration unit.
// Assumes: pin inputs are asynchronous; dma_done_i is a one-cycle strobe.
module busshare_ctrl
    import busshare_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       dma_req_i,
    input  logic       dma_ext_i,
    input  logic       dma_done_i,
    input  logic       insn_bound_i,
    input  logic       pin_a_i,
    input  logic       pin_b_i,
    output logic       pin_a_o,
    output logic       pin_a_oe,
    output logic       pin_b_o,
    output logic       pin_b_oe,
    output logic       dma_grant_o
);
    localparam int PIN_N = 2;

    bus_mode_e        mode;
    logic [PIN_N-1:0] pins_sync;
    logic             dma_need;
    logic             hold_out, holda_out, bus_own;

    assign mode     = bus_mode_e'(mode_i);
    assign dma_need = dma_req_i & dma_ext_i;

    busshare_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({pin_b_i, pin_a_i}),
        .q_o   (pins_sync)
    );

    busshare_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .dma_need_i   (dma_need),
        .dma_done_i   (dma_done_i),
        .insn_bound_i (insn_bound_i),
        .hold_in_i    (~pins_sync[0]),
        .holda_in_i   (~pins_sync[1]),
        .hold_out_o   (hold_out),
        .holda_out_o  (holda_out),
        .bus_own_o    (bus_own)
    );

    busshare_pins u_pins (
        .mode_i      (mode),
        .hold_out_i  (hold_out),
        .holda_out_i (holda_out),
        .pin_a_o     (pin_a_o),
        .pin_a_oe    (pin_a_oe),
        .pin_b_o     (pin_b_o),
        .pin_b_oe    (pin_b_oe)
    );

    // Purpose: pick the grant source; handshake-free when off, none when invalid.
    always_comb begin
        case (mode)
            MODE_OFF:     dma_grant_o = dma_need;
            MODE_INVALID: dma_grant_o = 1'b0;
            default:      dma_grant_o = bus_own;
        endcase
    end
endmodule

// File: rtl/busshare_ctrl_chk.sv
// Module: protocol checker bound to the arbitration unit top.
// Assumes: default of two synchronizer stages for the latency property.
module busshare_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       insn_bound_i,
    input logic       dma_done_i,
    input logic       pin_b_i,
    input logic       pin_a_oe,
    input logic       pin_b_o,
    input logic       pin_b_oe,
    input logic       dma_grant_o
);
    // R3
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |-> (!pin_a_oe && !pin_b_oe && !dma_grant_o));

    // R4
    req_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> (pin_a_oe && !pin_b_oe));

    // R6
    req_grant_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && $rose(dma_grant_o)) |-> ($past(pin_b_i, 3) == 1'b0));

    // R7
    req_grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && $stable(mode_i) && dma_grant_o && !dma_done_i) |=> dma_grant_o);

    // R9
    arb_ack_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pin_b_o) && pin_b_oe && $past(pin_b_oe)) |-> $past(insn_bound_i));

    // R10
    arb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> !(dma_grant_o && !pin_b_o));
endmodule

bind busshare_ctrl busshare_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .insn_bound_i (insn_bound_i),
    .dma_done_i   (dma_done_i),
    .pin_b_i      (pin_b_i),
    .pin_a_oe     (pin_a_oe),
    .pin_b_o      (pin_b_o),
    .pin_b_oe     (pin_b_oe),
    .dma_grant_o  (dma_grant_o)
);

// File: tb/sim_busshare_ctrl.sv
module sim_busshare_ctrl;
    localparam int SYNC = 2;
    localparam int LAT_PIN = SYNC + 1;   // pin edge to state reaction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic req = 0, ext = 0, done = 0, bound = 0;
    logic pa = 1'b1, pb = 1'b1;
    logic pa_o, pa_oe, pb_o, pb_oe, grant;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    busshare_ctrl #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dma_req_i(req), .dma_ext_i(ext),
        .dma_done_i(done), .insn_bound_i(bound), .pin_a_i(pa), .pin_b_i(pb),
        .pin_a_o(pa_o), .pin_a_oe(pa_oe), .pin_b_o(pb_o), .pin_b_oe(pb_oe),
        .dma_grant_o(grant)
    );

    task automatic chk(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // advance one edge, then settle past it
    task automatic step();
        @(posedge clk); #1;
    endtask

    // count edges until grant matches val (limit 12)
    task automatic edges_until_grant(input logic val, output int n);
        n = 0;
        while (grant !== val && n < 12) begin step(); n++; end
    endtask

    task automatic edges_until_pb(input logic val, output int n);
        n = 0;
        while (pb_o !== val && n < 12) begin step(); n++; end
    endtask

    initial begin
        int n;
        repeat (3) step();
        // R1 reset state
        chk("R1 grant", {7'd0, grant}, 8'd0);
        chk("R1 pins", {4'd0, pa_oe, pb_oe, pa_o, pb_o}, 8'h03);
        rst_n = 1'b1;
        step();

        // R2/R3 sweep over disabled codes and request combinations
        for (int m = 0; m < 4; m += 3) begin
            mode = m[1:0];
            step(); step();
            for (int c = 0; c < 4; c++) begin
                req = c[0]; ext = c[1];
                #1;
                if (m == 0) chk("R2 grant", {7'd0, grant}, {7'd0, c[0] & c[1]});
                else        chk("R3 grant", {7'd0, grant}, 8'd0);
                chk(m == 0 ? "R2 oe" : "R3 oe", {6'd0, pa_oe, pb_oe}, 8'd0);
                step();
            end
            req = 0; ext = 0;
        end

        // R4/R8 directions
        mode = 2'b01; #1;
        chk("R4 dir", {6'd0, pa_oe, pb_oe}, 8'h02);
        mode = 2'b10; #1;
        chk("R8 dir", {6'd0, pa_oe, pb_oe}, 8'h01);

        // requester mode: sweep HOLDA delay
        mode = 2'b01; step(); step();
        req = 1; ext = 0;
        repeat (4) step();
        chk("R5 internal-only", {7'd0, pa_o}, 8'd1);
        for (int d = 0; d < 5; d++) begin
            req = 1; ext = 1;
            step();
            chk("R5 hold low", {7'd0, pa_o}, 8'd0);
            repeat (d) step();
            chk("R6 no early grant", {7'd0, grant}, 8'd0);
            pb = 1'b0;
            edges_until_grant(1'b1, n);
            chk("R6 ack latency", n[7:0], LAT_PIN[7:0]);
            req = 0; ext = 0;
            repeat (2) step();
            chk("R7 grant held", {6'd0, grant, pa_o}, 8'h02);
            done = 1; step(); done = 0;
            chk("R7 release", {6'd0, grant, pa_o}, 8'h01);
            pb = 1'b1;
            repeat (4) step();
        end

        // R13 mode change while granted
        req = 1; ext = 1; step();
        pb = 1'b0; repeat (LAT_PIN) step();
        chk("R13 setup", {7'd0, grant}, 8'd1);
        req = 0; ext = 0;
        mode = 2'b10; step();
        chk("R13 abort", {6'd0, grant, pb_o}, 8'h01);
        pb = 1'b1;
        repeat (4) step();

        // arbiter: local DMA without external hold
        req = 1; ext = 0; repeat (3) step();
        chk("R12 internal-only", {7'd0, grant}, 8'd0);
        ext = 1; step();
        chk("R12 grant", {7'd0, grant}, 8'd1);
        req = 0; ext = 0;
        done = 1; step(); done = 0;
        chk("R12 release", {7'd0, grant}, 8'd0);

        // arbiter: sweep idle cycles before the instruction boundary
        for (int k = 0; k < 4; k++) begin
            pa = 1'b0;
            repeat (LAT_PIN + k) step();
            chk("R9 no ack without boundary", {7'd0, pb_o}, 8'd1);
            bound = 1; step(); bound = 0;
            chk("R9 ack at boundary", {7'd0, pb_o}, 8'd0);
            req = 1; ext = 1;
            repeat (3) step();
            chk("R10 local waits", {7'd0, grant}, 8'd0);
            pa = 1'b1;
            edges_until_pb(1'b1, n);
            chk("R11 release latency", n[7:0], LAT_PIN[7:0]);
            chk("R11 grant not yet", {7'd0, grant}, 8'd0);
            step();
            chk("R11 grant resumes", {7'd0, grant}, 8'd1);
            req = 0; ext = 0;
            done = 1; step(); done = 0;
        end

        // R10 external HOLD during local DMA waits for completion
        req = 1; ext = 1; step();
        req = 0; ext = 0;
        pa = 1'b0; bound = 1;
        repeat (5) step();
        chk("R10 dma keeps bus", {6'd0, grant, pb_o}, 8'h03);
        done = 1; step(); done = 0;
        step();
        chk("R10 ack after done", {6'd0, grant, pb_o}, 8'h00);
        bound = 0; pa = 1'b1;
        repeat (5) step();
        chk("R11 idle again", {7'd0, pb_o}, 8'd1);

        finished = 1;
    end

    initial begin : watchdog
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule